// File: doc/BRIEF.md
# Configurable asynchronous serial transmit framer

This block turns characters offered on a small valid/ready holding port into asynchronous serial frames. Every bit of a frame lasts one period of an externally supplied bit-rate enable pulse. A stored mode word chooses the character length, the parity rule and the stop length. Single-cycle command writes enable or disable the transmitter, start or end a break condition, or abort the transmit logic. The framing settings are captured when a character is accepted, so a mode write during a frame affects only later characters.

A loopback setting in the mode word sends the serial stream to the receive-side output and keeps the outgoing pin at the idle level. In normal operation the receive-side output follows the incoming line pin. The block sits between a transmit FIFO and the chip's serial pins.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, txd is 1, tx_busy is 0 and hold_ready is 0, because the transmitter starts disabled. The mode word resets to 0.
- R2: A frame is a start bit (0), then the data bits least significant first, then the parity bit if one is selected, then the stop bit or bits (1). Each bit lasts exactly one bit_tick period, and the start bit begins on a bit_tick edge after the character is accepted.
- R3: mode_data[2:1] sets the character length: 00 gives 8 bits, 10 gives 7 bits and 11 gives 6 bits. The code 01 gives 8 bits. Unused upper data bits are not sent.
- R4: mode_data[5:3] sets the parity. 000 is even (the parity bit makes the count of ones in the data and parity bits even) and 001 is odd. 010 always sends 0 and 011 always sends 1. Any value with bit 5 set sends no parity bit.
- R5: mode_data[7:6] = 10 sends two stop bits. Every other value sends one.
- R6: ctrl_data bit 4 enables the transmitter and bit 5 disables it, and disable wins when both are set. While disabled, hold_ready is 0, no character is accepted and the line stays at 1.
- R7: ctrl_data bit 7 starts a break and bit 8 ends it, and the end wins when both are set. Once the transmitter is idle, txd is held at 0 for the whole break. After the break ends, the line is 1 for at least one full bit_tick period before the next start bit.
- R8: ctrl_data bit 1 aborts any frame and any break. On the clock after the write, txd is 1 and tx_busy is 0, and the aborted frame does not resume. The abort wins over a break start in the same write.
- R9: mode_data[9:8] = 10 selects loopback: loop_rxd carries the serial stream, rxd_in is ignored and txd stays 1. Any other value gives normal operation, where loop_rxd follows rxd_in and txd carries the stream.
- R10: tx_busy is 1 from the start of the start bit to the end of the last stop bit, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-rate enable pulse |
| ctrl_wr | input | 1 | Command write strobe |
| ctrl_data | input | 9 | Command bits (1 abort, 4 enable, 5 disable, 7 break start, 8 break end) |
| mode_wr | input | 1 | Mode word write strobe |
| mode_data | input | 10 | Mode word (length, parity, stop, loopback) |
| hold_valid | input | 1 | A character is offered |
| hold_data | input | 8 | Offered character |
| hold_ready | output | 1 | The character is taken on this clock when hold_valid is 1 |
| rxd_in | input | 1 | Incoming serial line pin |
| txd | output | 1 | Outgoing serial line pin |
| loop_rxd | output | 1 | Receive-side serial input (rxd_in, or the stream in loopback) |
| tx_busy | output | 1 | A frame is on the line |

## Verification
Some command bits can arrive in the same write and contend with each other. An enable and a disable in one write must leave the transmitter off. A break start and an abort in one write must leave the line high, with no break. The bench issues both combined writes, holds a character on offer or watches the line for several bit periods afterwards, and requires no start bit and no low level. It also aborts a frame while a 0 data bit is on the line, and expects the line to be high on the very next clock and to stay idle.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PEND, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK, ST_GAP
  } txf_state_e;

  typedef enum logic [1:0] {
    PK_EVEN, PK_ODD, PK_ZERO, PK_ONE
  } par_kind_e;

  typedef struct packed {
    logic [3:0] trim;       // data bits dropped from the full width
    logic       par_en;
    par_kind_e  par_kind;
    logic       two_stop;
    logic       loop;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_mode(input logic [9:0] m);
    frame_cfg_t c;
    case (m[2:1])
      2'b11:   c.trim = 4'd2;
      2'b10:   c.trim = 4'd1;
      default: c.trim = 4'd0;
    endcase
    c.par_en   = ~m[5];
    c.par_kind = par_kind_e'(m[4:3]);
    c.two_stop = (m[7:6] == 2'b10);
    c.loop     = (m[9:8] == 2'b10);
    return c;
  endfunction

endpackage

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import uart_txf_pkg::*;
#(
  parameter int CTRL_W = 9,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  output logic              tx_en,
  output logic              brk_on,
  output logic              tx_rst,
  output frame_cfg_t        cfg
);
  localparam int RST_BIT  = 1;
  localparam int EN_BIT   = 4;
  localparam int DIS_BIT  = 5;
  localparam int BRK_SET  = 7;
  localparam int BRK_CLR  = 8;

  logic              en_d, brk_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              unused_bits;

  assign tx_rst = ctrl_wr & ctrl_data[RST_BIT];

  always_comb begin
    en_d   = tx_en;
    brk_d  = brk_on;
    mode_d = mode_q;
    if (ctrl_wr) begin
      if (ctrl_data[DIS_BIT])      en_d = 1'b0;
      else if (ctrl_data[EN_BIT])  en_d = 1'b1;
      if (ctrl_data[BRK_CLR])      brk_d = 1'b0;
      else if (ctrl_data[BRK_SET]) brk_d = 1'b1;
      if (ctrl_data[RST_BIT])      brk_d = 1'b0;
    end
    if (mode_wr) mode_d = mode_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      brk_on <= 1'b0;
      mode_q <= '0;
    end else begin
      tx_en  <= en_d;
      brk_on <= brk_d;
      mode_q <= mode_d;
    end
  end

  assign cfg = decode_mode(mode_q[9:0]);

  assign unused_bits = ^{mode_q[0], ctrl_data[0], ctrl_data[3:2], ctrl_data[6]};

  // R6: a write carrying the disable bit always leaves the transmitter off
  a_r6_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_data[DIS_BIT]) |=> !tx_en);

  // R8: the abort command cancels any break request
  a_r8_abort_clears_break: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_data[RST_BIT]) |=> !brk_on);

endmodule

// File: rtl/txf_frame.sv
module txf_frame
  import uart_txf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              brk_on,
  input  logic              tx_rst,
  input  logic [3:0]        trim,
  input  logic              par_en,
  input  par_kind_e         par_kind,
  input  logic              two_stop,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  output logic              hold_ready,
  output logic              ser,
  output logic              busy
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  txf_state_e        st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d, keep, masked;
  logic [CNT_W-1:0]  left_q, left_d, nbits;
  logic              pbit_q, pbit_d, pen_q, pen_d, extra_q, extra_d;
  logic              par_calc, accept;

  assign nbits = CNT_W'(DATA_W) - CNT_W'(trim);

  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    assign keep[i] = (CNT_W'(i) < nbits);
  end
  assign masked = hold_data & keep;

  always_comb begin
    case (par_kind)
      PK_EVEN: par_calc = ^masked;
      PK_ODD:  par_calc = ~^masked;
      PK_ZERO: par_calc = 1'b0;
      default: par_calc = 1'b1;
    endcase
  end

  assign hold_ready = (st_q == ST_IDLE) && tx_en && !brk_on && !tx_rst;
  assign accept     = hold_valid && hold_ready;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    left_d  = left_q;
    pbit_d  = pbit_q;
    pen_d   = pen_q;
    extra_d = extra_q;
    case (st_q)
      ST_IDLE: begin
        if (brk_on) st_d = ST_BRK;
        else if (accept) begin
          st_d    = ST_PEND;
          sh_d    = masked;
          left_d  = nbits;
          pbit_d  = par_calc;
          pen_d   = par_en;
          extra_d = two_stop;
        end
      end
      ST_PEND:  if (bit_tick) st_d = ST_START;
      ST_START: if (bit_tick) st_d = ST_DATA;
      ST_DATA: begin
        if (bit_tick) begin
          sh_d   = sh_q >> 1;
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) st_d = pen_q ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR:   if (bit_tick) st_d = ST_STOP;
      ST_STOP: begin
        if (bit_tick) begin
          if (extra_q) extra_d = 1'b0;
          else         st_d    = ST_IDLE;
        end
      end
      ST_BRK:   if (!brk_on) st_d = ST_GAP;
      ST_GAP:   if (bit_tick) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (tx_rst) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      pbit_q  <= 1'b0;
      pen_q   <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      pbit_q  <= pbit_d;
      pen_q   <= pen_d;
      extra_q <= extra_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_START: ser = 1'b0;
      ST_DATA:  ser = sh_q[0];
      ST_PAR:   ser = pbit_q;
      ST_BRK:   ser = 1'b0;
      default:  ser = 1'b1;
    endcase
  end

  assign busy = (st_q == ST_START) || (st_q == ST_DATA) ||
                (st_q == ST_PAR)   || (st_q == ST_STOP);

  // R8: abort leaves the line idle on the next clock
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (ser && !busy));

  // R2: within a frame the line only moves on a bit-rate edge
  a_r2_bit_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick && !tx_rst) |=> $stable(ser));

  // R10: the busy interval opens with the start bit
  a_r10_busy_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ser);

  // R7: a pending break pulls an idle line low on the next clock
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_on && st_q == ST_IDLE && !tx_rst) |=> !ser);

endmodule

// File: rtl/txf_line_mux.sv
module txf_line_mux (
  input  logic loop,
  input  logic ser,
  input  logic rxd_in,
  output logic txd,
  output logic loop_rxd
);
  assign txd      = loop ? 1'b1 : ser;
  assign loop_rxd = loop ? ser  : rxd_in;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_txf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 9,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  output logic              hold_ready,
  input  logic              rxd_in,
  output logic              txd,
  output logic              loop_rxd,
  output logic              tx_busy
);
  logic       tx_en, brk_on, tx_rst, ser;
  frame_cfg_t cfg;

  txf_ctrl #(.CTRL_W(CTRL_W), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .mode_wr(mode_wr), .mode_data(mode_data), .tx_en(tx_en),
    .brk_on(brk_on), .tx_rst(tx_rst), .cfg(cfg)
  );

  txf_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .brk_on(brk_on), .tx_rst(tx_rst), .trim(cfg.trim), .par_en(cfg.par_en),
    .par_kind(cfg.par_kind), .two_stop(cfg.two_stop),
    .hold_valid(hold_valid), .hold_data(hold_data), .hold_ready(hold_ready),
    .ser(ser), .busy(tx_busy)
  );

  txf_line_mux u_mux (
    .loop(cfg.loop), .ser(ser), .rxd_in(rxd_in), .txd(txd), .loop_rxd(loop_rxd)
  );

  // R9: in loopback the outgoing pin stays idle while the framer runs
  a_r9_loop_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.loop && tx_busy) |-> txd);

endmodule

// File: tb/uart_tx_framer_test.sv
module uart_tx_framer_test;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_tick;
  logic       ctrl_wr;
  logic [8:0] ctrl_data;
  logic       mode_wr;
  logic [9:0] mode_data;
  logic       hold_valid;
  logic [7:0] hold_data;
  logic       hold_ready;
  logic       rxd_in;
  logic       txd, loop_rxd, tx_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  uart_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ctrl_wr(ctrl_wr),
    .ctrl_data(ctrl_data), .mode_wr(mode_wr), .mode_data(mode_data),
    .hold_valid(hold_valid), .hold_data(hold_data), .hold_ready(hold_ready),
    .rxd_in(rxd_in), .txd(txd), .loop_rxd(loop_rxd), .tx_busy(tx_busy)
  );

  always #4 clk = ~clk;

  initial begin
    int tcnt;
    tcnt = 0;
    bit_tick = 1'b0;
    forever begin
      @(negedge clk);
      tcnt = (tcnt == DIV - 1) ? 0 : tcnt + 1;
      bit_tick = (tcnt == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic cmd(input logic [8:0] bits);
    @(negedge clk);
    ctrl_data = bits;
    ctrl_wr   = 1'b1;
    @(negedge clk);
    ctrl_wr   = 1'b0;
    ctrl_data = '0;
  endtask

  task automatic set_mode(input logic [9:0] m);
    @(negedge clk);
    mode_data = m;
    mode_wr   = 1'b1;
    @(negedge clk);
    mode_wr   = 1'b0;
  endtask

  task automatic build(input logic [7:0] d, input logic [9:0] m,
                       output logic [15:0] e, output int n);
    int nb;
    logic [7:0] md;
    logic p;
    nb = (m[2:1] == 2'b11) ? 6 : (m[2:1] == 2'b10) ? 7 : 8;
    md = d & 8'((1 << nb) - 1);
    e = '1;
    n = 0;
    e[n] = 1'b0; n++;
    for (int i = 0; i < nb; i++) begin e[n] = md[i]; n++; end
    if (!m[5]) begin
      case (m[4:3])
        2'b00: p = ^md;
        2'b01: p = ~^md;
        2'b10: p = 1'b0;
        default: p = 1'b1;
      endcase
      e[n] = p; n++;
    end
    e[n] = 1'b1; n++;
    if (m[7:6] == 2'b10) begin e[n] = 1'b1; n++; end
  endtask

  task automatic offer(input logic [7:0] d);
    for (int k = 0; k < 200 && !hold_ready; k++) @(negedge clk);
    hold_data  = d;
    hold_valid = 1'b1;
    @(negedge clk);
    hold_valid = 1'b0;
  endtask

  task automatic wait_start(input bit use_loop, output bit found);
    found = 0;
    for (int k = 0; k < 4 * DIV; k++) begin
      if ((use_loop ? loop_rxd : txd) == 1'b0) begin found = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [9:0] m,
                            input bit use_loop, input string tag);
    logic [15:0] e, got;
    int n;
    bit found, busy_ok, pin_ok;
    build(d, m, e, n);
    set_mode(m);
    offer(d);
    wait_start(use_loop, found);
    check(found, {tag, " start bit seen"}, found, 1);
    got = '1;
    busy_ok = 1;
    pin_ok = 1;
    repeat (DIV / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = use_loop ? loop_rxd : txd;
      if (!tx_busy) busy_ok = 0;
      if (use_loop && !txd) pin_ok = 0;
      repeat (DIV) @(negedge clk);
    end
    check(got == e, {tag, " frame bits"}, got, e);
    check(busy_ok, "R10 busy through frame", busy_ok, 1);
    check(!tx_busy && (use_loop ? loop_rxd : txd), "R10 idle after last stop",
          {tx_busy, txd}, 1);
    if (use_loop) check(pin_ok, "R9 txd idle in loopback", pin_ok, 1);
  endtask

  task automatic t_reset();
    check(txd === 1'b1 && tx_busy === 1'b0 && hold_ready === 1'b0,
          "R1 reset state", {txd, tx_busy, hold_ready}, 3'b100);
  endtask

  task automatic t_enable();
    bit stayed;
    cmd(9'h010);
    check(hold_ready, "R6 ready after enable", hold_ready, 1);
    cmd(9'h030);
    check(!hold_ready, "R6 disable wins over enable", hold_ready, 0);
    hold_data  = 8'h00;
    hold_valid = 1'b1;
    stayed = 1;
    repeat (4 * DIV) begin
      @(negedge clk);
      if (!txd || tx_busy) stayed = 0;
    end
    hold_valid = 1'b0;
    check(stayed, "R6 no frame while disabled", stayed, 1);
    cmd(9'h010);
  endtask

  task automatic t_frames();
    send_frame(8'hA5, 10'h020, 0, "R2 R3 8-bit no parity");
    send_frame(8'h5B, 10'h004, 0, "R3 R4 7-bit even");
    send_frame(8'h2D, 10'h08E, 0, "R4 R5 6-bit odd two stop");
    send_frame(8'hFF, 10'h014, 0, "R4 7-bit zero parity");
    send_frame(8'h00, 10'h018, 0, "R4 8-bit one parity");
    send_frame(8'h3C, 10'h0A0, 0, "R5 8-bit two stop");
    send_frame(8'hC6, 10'h002, 0, "R3 code 01 gives 8 bits");
  endtask

  task automatic t_break();
    bit low_ok, high_ok, found;
    int cnt;
    set_mode(10'h020);
    cmd(9'h080);
    @(negedge clk);
    low_ok = 1;
    repeat (3 * DIV) begin
      if (txd) low_ok = 0;
      @(negedge clk);
    end
    check(low_ok, "R7 line low during break", txd, 0);
    hold_data  = 8'h55;
    hold_valid = 1'b1;
    cmd(9'h100);
    cnt = 0;
    found = 0;
    high_ok = 1;
    for (int k = 0; k < 6 * DIV; k++) begin
      @(negedge clk);
      cnt++;
      if (!txd) begin found = 1; break; end
    end
    hold_valid = 1'b0;
    check(found && cnt >= DIV, "R7 idle gap after break", cnt, DIV);
    for (int k = 0; k < 20 * DIV && tx_busy; k++) @(negedge clk);
    check(!tx_busy && txd, "R7 frame after break completes", {tx_busy, txd}, 1);
  endtask

  task automatic t_abort();
    bit found, idle_ok;
    set_mode(10'h020);
    offer(8'h00);
    wait_start(0, found);
    repeat (2 * DIV + DIV / 2) @(negedge clk);
    check(!txd, "R8 data bit low before abort", txd, 0);
    cmd(9'h002);
    check(txd && !tx_busy, "R8 abort idles line next clock", {txd, tx_busy}, 2'b10);
    idle_ok = 1;
    repeat (3 * DIV) begin
      @(negedge clk);
      if (!txd || tx_busy) idle_ok = 0;
    end
    check(idle_ok, "R8 aborted frame does not resume", idle_ok, 1);
    cmd(9'h082);
    idle_ok = 1;
    repeat (2 * DIV) begin
      @(negedge clk);
      if (!txd) idle_ok = 0;
    end
    check(idle_ok, "R8 abort wins over break start", idle_ok, 1);
    cmd(9'h080);
    @(negedge clk);
    check(!txd, "R7 break asserted", txd, 0);
    cmd(9'h002);
    check(txd, "R8 abort ends break", txd, 1);
    repeat (2 * DIV) @(negedge clk);
    send_frame(8'h96, 10'h020, 0, "R8 frame after abort");
  endtask

  task automatic t_loop();
    rxd_in = 1'b0;
    send_frame(8'hC3, 10'h220, 1, "R9 loopback frame");
    check(loop_rxd, "R9 rxd_in ignored in loopback", loop_rxd, 1);
    set_mode(10'h020);
    @(negedge clk);
    check(!loop_rxd, "R9 loop_rxd follows rxd_in low", loop_rxd, 0);
    rxd_in = 1'b1;
    @(negedge clk);
    check(loop_rxd, "R9 loop_rxd follows rxd_in high", loop_rxd, 1);
    send_frame(8'h69, 10'h320, 0, "R9 code 11 is normal");
  endtask

  initial begin
    rst_n      = 1'b0;
    ctrl_wr    = 1'b0;
    ctrl_data  = '0;
    mode_wr    = 1'b0;
    mode_data  = '0;
    hold_valid = 1'b0;
    hold_data  = '0;
    rxd_in     = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_frames();
    t_break();
    t_abort();
    t_loop();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule